// File: doc/BRIEF.md
# Crossbar Output Arbiter with Two Priority Levels and Request Aging

This block decides, for every output of an 8-port switch crossbar, which requester may drive it. A requester is one virtual channel of one input port. With two channels per port there are 16 requesters, numbered `port * VCS + vc`. Each requester presents a valid flag, a priority bit and an output mask. A mask with one bit set is a unicast request. A mask with several bits set is a broadcast that needs every named output at the same time.

Arbitration runs every cycle over the outputs that are idle. High priority beats low priority. Inside one priority level, the request that has waited longest wins. A 4-bit wait counter per requester records that waiting time. When two requests have the same wait, the lower requester index wins. A grant is registered. It stays in place for the whole packet and is dropped only when the owner flags the last flit. A broadcast is granted on all of its outputs in one step, or it is not granted at all.

Top module: `xbar_prio_arb`

## Requirements
- R1: After reset, `gnt_mask`, `out_busy`, `out_owner` and every `req_age` field are zero.
- R2: A valid unicast request to an idle output with no competitor appears in the next cycle. Bit `r*PORTS+o` of `gnt_mask` rises, `out_busy[o]` rises and `out_owner` field `o` (bits `o*IDXW +: IDXW`) holds `r`.
- R3: A grant stays unchanged until its owner raises `req_last` for one cycle. The grant and the busy flag clear in the next cycle, and a waiting requester can be granted in the cycle after that.
- R4: A high-priority request (`req_hi`=1) beats any low-priority request for the same output, whatever the low request's age.
- R5: Within one priority level, the larger `req_age` wins. On equal age, the lower requester index wins.
- R6: `req_age` of requester r increments on each cycle in which it is valid, holds no grant and is not granted. It saturates at 15. It returns to 0 when the requester is granted or drops `req_valid`.
- R7: A broadcast request is granted only when all of its masked outputs are idle, and then on all of them in the same cycle. While any masked output is busy, none of its outputs is granted to it.
- R8: Requests for disjoint outputs are granted in the same cycle. A requester's grant equals the mask it requested, so a unicast requester holds exactly one output.
- R9: A valid request with an all-zero mask is never granted and leaves every output idle.
- R10: No output is ever held by more than one requester, and a busy output's owner field names a requester whose grant includes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NREQ (16) | Request present, one bit per requester |
| req_hi | input | NREQ (16) | 1 = high priority, 0 = low priority |
| req_mask | input | NREQ*PORTS (128) | Requested outputs, field r at bits r*PORTS +: PORTS |
| req_last | input | NREQ (16) | Owner is sending the last flit of its packet |
| gnt_mask | output | NREQ*PORTS (128) | Outputs currently held, field r at bits r*PORTS +: PORTS |
| out_busy | output | PORTS (8) | Output held by some requester |
| out_owner | output | PORTS*IDXW (32) | Requester index holding each output |
| req_age | output | NREQ*AGE_W (64) | Wait counter per requester |

## Verification
The bound checker enforces the structural invariants on every cycle. An output is never shared, and owner fields agree with the grants. A grant stays put until the last flit and clears right after it. A new grant always equals the full requested mask, so broadcasts are atomic. A saturated age stays saturated until its requester is granted. Whether the right requester won cannot be judged cycle by cycle without a model. The directed scenarios show that: high priority against an older low request, age ordering and index tie-breaking, a broadcast waiting on a busy output while unicasts proceed, and the two-cycle release-to-regrant sequence.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

    localparam int XB_PORTS_DEF = 8;
    localparam int XB_VCS_DEF   = 2;
    localparam int XB_AGE_W_DEF = 4;

    // index width with a floor of one bit
    function automatic int xb_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/xbar_age_ctr.sv
module xbar_age_ctr #(
    parameter int AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             holding_i,
    input  logic             won_i,
    output logic [AGE_W-1:0] age_o
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [AGE_W-1:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (!valid_i || holding_i || won_i) begin
            age_d = '0;
        end else if (age_q != AGE_MAX) begin
            age_d = age_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    assign age_o = age_q;
endmodule

// File: rtl/xbar_out_pick.sv
module xbar_out_pick #(
    parameter int NREQ = 16,
    parameter int KEYW = 9,
    parameter int IDXW = 4
) (
    input  logic [NREQ-1:0]      cand_i,
    input  logic [NREQ*KEYW-1:0] keys_i,
    output logic                 vld_o,
    output logic [IDXW-1:0]      idx_o
);
    logic [KEYW-1:0] best;

    // keys are unique, so the largest one is a single winner
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        best  = '0;
        for (int r = 0; r < NREQ; r++) begin
            if (cand_i[r] && (!vld_o || keys_i[r*KEYW +: KEYW] > best)) begin
                vld_o = 1'b1;
                best  = keys_i[r*KEYW +: KEYW];
                idx_o = IDXW'(r);
            end
        end
    end
endmodule

// File: rtl/xbar_prio_arb.sv
module xbar_prio_arb
    import xbar_arb_pkg::*;
#(
    parameter int PORTS = XB_PORTS_DEF,
    parameter int VCS   = XB_VCS_DEF,
    parameter int AGE_W = XB_AGE_W_DEF,
    localparam int NREQ = PORTS * VCS,
    localparam int IDXW = xb_idx_w(NREQ)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREQ-1:0]         req_valid,
    input  logic [NREQ-1:0]         req_hi,
    input  logic [NREQ*PORTS-1:0]   req_mask,
    input  logic [NREQ-1:0]         req_last,
    output logic [NREQ*PORTS-1:0]   gnt_mask,
    output logic [PORTS-1:0]        out_busy,
    output logic [PORTS*IDXW-1:0]   out_owner,
    output logic [NREQ*AGE_W-1:0]   req_age
);
    localparam int KEYW = 1 + AGE_W + IDXW;

    typedef struct packed {
        logic [PORTS-1:0]                busy;
        logic [PORTS-1:0][IDXW-1:0]      owner;
        logic [NREQ-1:0][PORTS-1:0]      hold;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NREQ-1:0][PORTS-1:0] mask_w;
    logic [NREQ-1:0][AGE_W-1:0] age_w;
    logic [NREQ-1:0]            elig;
    logic [NREQ-1:0]            won;
    logic [NREQ-1:0]            holding;
    logic [NREQ*KEYW-1:0]       keys;
    logic [PORTS-1:0][NREQ-1:0] cand;
    logic [PORTS-1:0]           win_vld;
    logic [PORTS-1:0][IDXW-1:0] win_idx;

    assign mask_w = req_mask;

    // eligibility and ordering keys: priority, then age, then lower index
    always_comb begin
        for (int r = 0; r < NREQ; r++) begin
            holding[r] = (st_q.hold[r] != '0);
            elig[r]    = req_valid[r] && !holding[r] && (mask_w[r] != '0)
                         && ((mask_w[r] & st_q.busy) == '0);
            keys[r*KEYW +: KEYW] = {req_hi[r], age_w[r], ~IDXW'(r)};
        end
        for (int o = 0; o < PORTS; o++) begin
            for (int r = 0; r < NREQ; r++) begin
                cand[o][r] = elig[r] && mask_w[r][o];
            end
        end
    end

    generate
        for (genvar go = 0; go < PORTS; go++) begin : g_pick
            xbar_out_pick #(.NREQ(NREQ), .KEYW(KEYW), .IDXW(IDXW)) u_pick (
                .cand_i (cand[go]),
                .keys_i (keys),
                .vld_o  (win_vld[go]),
                .idx_o  (win_idx[go])
            );
        end
    endgenerate

    // a requester wins only if it won every output in its mask
    always_comb begin
        for (int r = 0; r < NREQ; r++) begin
            won[r] = elig[r];
            for (int o = 0; o < PORTS; o++) begin
                if (mask_w[r][o] && !(win_vld[o] && win_idx[o] == IDXW'(r))) begin
                    won[r] = 1'b0;
                end
            end
        end
    end

    generate
        for (genvar gr = 0; gr < NREQ; gr++) begin : g_age
            xbar_age_ctr #(.AGE_W(AGE_W)) u_age (
                .clk       (clk),
                .rst_n     (rst_n),
                .valid_i   (req_valid[gr]),
                .holding_i (holding[gr]),
                .won_i     (won[gr]),
                .age_o     (age_w[gr])
            );
        end
    endgenerate

    // next state: releases first, then new grants onto idle outputs
    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NREQ; r++) begin
            if (holding[r] && req_last[r]) begin
                for (int o = 0; o < PORTS; o++) begin
                    if (st_q.hold[r][o]) begin
                        st_d.busy[o]  = 1'b0;
                        st_d.owner[o] = '0;
                    end
                end
                st_d.hold[r] = '0;
            end
        end
        for (int r = 0; r < NREQ; r++) begin
            if (won[r]) begin
                st_d.hold[r] = mask_w[r];
                for (int o = 0; o < PORTS; o++) begin
                    if (mask_w[r][o]) begin
                        st_d.busy[o]  = 1'b1;
                        st_d.owner[o] = IDXW'(r);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt_mask  = st_q.hold;
    assign out_busy  = st_q.busy;
    assign out_owner = st_q.owner;
    assign req_age   = age_w;
endmodule

// File: rtl/xbar_prio_arb_chk.sv
module xbar_prio_arb_chk #(
    parameter int PORTS = 8,
    parameter int VCS   = 2,
    parameter int AGE_W = 4,
    localparam int NREQ = PORTS * VCS,
    localparam int IDXW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NREQ-1:0]       req_valid,
    input logic [NREQ*PORTS-1:0] req_mask,
    input logic [NREQ-1:0]       req_last,
    input logic [NREQ*PORTS-1:0] gnt_mask,
    input logic [PORTS-1:0]      out_busy,
    input logic [PORTS*IDXW-1:0] out_owner,
    input logic [NREQ*AGE_W-1:0] req_age
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    generate
        for (genvar o = 0; o < PORTS; o++) begin : g_out
            logic [NREQ-1:0] col;
            always_comb begin
                for (int r = 0; r < NREQ; r++) col[r] = gnt_mask[r*PORTS + o];
            end
            // R10
            single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(col) <= 1 && (out_busy[o] == (col != '0)));
            // R10
            owner_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_busy[o] |-> col[out_owner[o*IDXW +: IDXW]]);
        end
        for (genvar r = 0; r < NREQ; r++) begin : g_req
            // R3
            grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_mask[r*PORTS +: PORTS] != '0 && !req_last[r])
                |=> gnt_mask[r*PORTS +: PORTS] == $past(gnt_mask[r*PORTS +: PORTS]));
            // R3
            grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_mask[r*PORTS +: PORTS] != '0 && req_last[r])
                |=> gnt_mask[r*PORTS +: PORTS] == '0);
            // R7 R8
            full_mask_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_mask[r*PORTS +: PORTS] == '0)
                |=> (gnt_mask[r*PORTS +: PORTS] == '0 ||
                     gnt_mask[r*PORTS +: PORTS] == $past(req_mask[r*PORTS +: PORTS])));
            // R6
            age_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req_age[r*AGE_W +: AGE_W] == AGE_MAX && req_valid[r]
                 && gnt_mask[r*PORTS +: PORTS] == '0)
                |=> (req_age[r*AGE_W +: AGE_W] == AGE_MAX ||
                     gnt_mask[r*PORTS +: PORTS] != '0));
        end
    endgenerate
endmodule

bind xbar_prio_arb xbar_prio_arb_chk #(.PORTS(PORTS), .VCS(VCS), .AGE_W(AGE_W)) u_chk (.*);

// File: tb/xbar_prio_arb_tb.sv
module xbar_prio_arb_tb;
    localparam int P    = 8;
    localparam int NREQ = 16;
    localparam int IDXW = 4;
    localparam int AW   = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NREQ-1:0]     req_valid = '0;
    logic [NREQ-1:0]     req_hi = '0;
    logic [NREQ*P-1:0]   req_mask = '0;
    logic [NREQ-1:0]     req_last = '0;
    logic [NREQ*P-1:0]   gnt_mask;
    logic [P-1:0]        out_busy;
    logic [P*IDXW-1:0]   out_owner;
    logic [NREQ*AW-1:0]  req_age;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    xbar_prio_arb u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hi(req_hi),
        .req_mask(req_mask), .req_last(req_last), .gnt_mask(gnt_mask),
        .out_busy(out_busy), .out_owner(out_owner), .req_age(req_age)
    );

    function automatic logic [P-1:0] gnt(input int r);
        return gnt_mask[r*P +: P];
    endfunction
    function automatic logic [AW-1:0] age(input int r);
        return req_age[r*AW +: AW];
    endfunction
    function automatic logic [IDXW-1:0] owner(input int o);
        return out_owner[o*IDXW +: IDXW];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_req(input int r, input logic hi, input logic [P-1:0] m);
        req_valid[r] = 1'b1;
        req_hi[r] = hi;
        req_mask[r*P +: P] = m;
    endtask

    task automatic drop(input int r);
        req_valid[r] = 1'b0;
    endtask

    task automatic release_req(input int r);
        req_last[r] = 1'b1;
        step();
        req_last[r] = 1'b0;
    endtask

    task automatic clean();
        req_valid = '0;
        for (int r = 0; r < NREQ; r++) req_last[r] = (gnt(r) != '0);
        step();
        req_last = '0;
        step();
    endtask

    task automatic t_reset();
        chk("R1 gnt_mask", gnt_mask[31:0] | gnt_mask[127:96], 0);
        chk("R1 out_busy", out_busy, 0);
        chk("R1 out_owner", out_owner, 0);
        chk("R1 req_age", req_age[31:0] | req_age[63:32], 0);
    endtask

    task automatic t_unicast_hold();
        set_req(3, 1'b0, 8'h04);
        step();
        chk("R2 gnt r3", gnt(3), 32'h04);
        chk("R2 busy", out_busy, 32'h04);
        chk("R2 owner o2", owner(2), 3);
        drop(3);
        set_req(5, 1'b1, 8'h04);
        step(3);
        chk("R3 gnt r3 held", gnt(3), 32'h04);
        chk("R3 r5 blocked", gnt(5), 0);
        chk("R6 r5 age", age(5), 3);
        release_req(3);
        chk("R3 r3 released", gnt(3), 0);
        chk("R3 out2 idle", out_busy[2], 0);
        chk("R3 r5 not yet", gnt(5), 0);
        step();
        chk("R3 r5 granted", gnt(5), 32'h04);
        chk("R6 r5 age cleared", age(5), 0);
        clean();
    endtask

    task automatic t_priority();
        set_req(15, 1'b0, 8'h01);
        step();
        drop(15);
        set_req(1, 1'b0, 8'h01);
        step(5);
        set_req(9, 1'b1, 8'h01);
        step();
        release_req(15);
        step();
        chk("R4 hi wins", gnt(9), 32'h01);
        chk("R4 older lo loses", gnt(1), 0);
        chk("R4 owner", owner(0), 9);
        clean();
    endtask

    task automatic t_age_order();
        set_req(0, 1'b0, 8'h02);
        step();
        drop(0);
        set_req(6, 1'b0, 8'h02);
        step(3);
        set_req(2, 1'b0, 8'h02);
        step();
        chk("R6 r6 age", age(6), 4);
        chk("R6 r2 age", age(2), 1);
        release_req(0);
        step();
        chk("R5 older wins", gnt(6), 32'h02);
        chk("R5 younger waits", gnt(2), 0);
        chk("R6 loser keeps aging", age(2), 3);
        clean();
        set_req(11, 1'b0, 8'h08);
        set_req(4, 1'b0, 8'h08);
        step();
        chk("R5 tie low index", gnt(4), 32'h08);
        chk("R5 tie loser", gnt(11), 0);
        chk("R6 tie loser age", age(11), 1);
        clean();
    endtask

    task automatic t_saturate();
        set_req(15, 1'b0, 8'h20);
        step();
        drop(15);
        set_req(7, 1'b0, 8'h20);
        step(20);
        chk("R6 saturate", age(7), 15);
        drop(7);
        step();
        chk("R6 withdraw clears", age(7), 0);
        clean();
    endtask

    task automatic t_broadcast();
        set_req(12, 1'b0, 8'h04);
        step();
        drop(12);
        set_req(8, 1'b1, 8'h0E);
        set_req(13, 1'b0, 8'h02);
        step();
        chk("R7 bcast blocked", gnt(8), 0);
        chk("R7 no partial out3", out_busy[3], 0);
        chk("R7 unicast proceeds", gnt(13), 32'h02);
        drop(13);
        req_last[12] = 1'b1;
        req_last[13] = 1'b1;
        step();
        req_last = '0;
        chk("R7 bcast waits release", gnt(8), 0);
        step();
        chk("R7 bcast atomic", gnt(8), 32'h0E);
        chk("R7 busy", out_busy, 32'h0E);
        chk("R7 owner o3", owner(3), 8);
        clean();
        set_req(3, 1'b0, 8'h10);
        set_req(10, 1'b1, 8'h30);
        set_req(1, 1'b0, 8'h40);
        step();
        chk("R8 bcast beats unicast", gnt(10), 32'h30);
        chk("R8 unicast loser", gnt(3), 0);
        chk("R8 disjoint parallel", gnt(1), 32'h40);
        chk("R8 busy", out_busy, 32'h70);
        clean();
    endtask

    task automatic t_zero_mask();
        set_req(2, 1'b1, 8'h00);
        step(2);
        chk("R9 zero mask no grant", gnt(2), 0);
        chk("R9 outputs idle", out_busy, 0);
        clean();
    endtask

    initial begin
        step(2);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_unicast_hold();
        t_priority();
        t_age_order();
        t_saturate();
        t_broadcast();
        t_zero_mask();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule